// File: doc/BRIEF.md
# Buffered SPI Host Engine

This block is an SPI host that moves whole buffers instead of single bytes. Software fills an on-chip command buffer through a small memory-mapped port. It then writes one control word that carries the peripheral index, the byte count, a clock speed code, the clock mode and a go bit. The engine clocks the command bytes out on MOSI and, in the same bit slots, stores the bytes arriving on MISO into a response buffer. Software reads that buffer back once the transfer is over.

When the last byte is done, the engine releases chip select and clears the go bit. It also latches a completion event that is cleared by writing a one to it. A mask register decides whether the event drives the interrupt line. A force bit keeps the selected chip-select line low between transfers, so that several buffer bursts can form one longer message on the wire. The serial clock is derived from the system clock through a fixed divider table indexed by the speed code.

Top module: `spibuf_host`

Address map (byte addresses on `busAddr`):

| Region | Address |
|---|---|
| Command buffer | 0x000 to 0x13F |
| Response buffer | 0x200 to 0x33F |
| Control word | 0x400 |
| Event register | 0x420 |
| Event mask | 0x424 |

Control word fields:

| Field | Bits |
|---|---|
| go | 0 |
| clock mode | 2 |
| force select | 4 |
| speed code | 7:5 |
| byte count | 16:8 |
| peripheral index | 27:25 |

## Requirements
- R1: After reset, all seven active-low chip-select outputs are high, the serial clock is low and the interrupt is low. The control word at 0x400 reads 0 and the event register at 0x420 reads 0.
- R2: Setting go (bit 0 of the control word) with a byte count N (bits 16:8) from 1 to 320 sends command buffer bytes 0 to N-1 in order, each byte MSB first. The MISO byte received in slot k is written to the response buffer at 0x200+k.
- R3: Clock mode bit 2 selects the mode. When it is 0 the serial clock idles low (mode 0). When it is 1 the serial clock idles high (mode 3). In both modes MISO is sampled at the rising clock edge and MOSI changes after the falling edge.
- R4: The speed code (bits 7:5) sets the serial clock period in system clock cycles. Codes 0 to 4 give 2, 3, 4, 5 and 6 cycles. Codes 5, 6 and 7 give 30 cycles.
- R5: While a transfer runs, or while the force bit 4 is 1, exactly the chip-select line given by the peripheral index (bits 27:25) is low. An index of 7 drives no line low. Clearing force while idle releases the line.
- R6: When a transfer completes, bit 8 of the event register sets, the go bit reads back 0, and chip select is released. While the transfer runs, go reads back 1.
- R7: Writing a 1 to event bit 8 clears it. If the clear lands in the same cycle as a completion, the completion wins and the bit stays set.
- R8: The interrupt output is high exactly when event bit 8 is set and bit 8 of the mask register at 0x424 is set.
- R9: A write to the control word while a transfer is in progress leaves every control field unchanged.
- R10: A go with a byte count of 0 sets event bit 8 on the same clock edge. No serial clock edge occurs and no chip select is asserted.
- R11: A byte count above 320 runs exactly 320 bytes. The control word still reads back the count as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register/buffer write strobe |
| busRdEn | input | 1 | Register/buffer read strobe; data returns on the next cycle |
| busAddr | input | 11 | Byte address |
| busWrData | input | 32 | Write data (buffers use bits 7:0) |
| busRdData | output | 32 | Read data, registered |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Host data out |
| spiMiso | input | 1 | Peripheral data in |
| spiCsN | output | 7 | Active-low chip selects |
| irq | output | 1 | Masked completion interrupt |

## Verification
Two events can fall on the same clock edge: the engine setting the completion event, and software clearing that event with a write-one. The bench provokes this with a one-byte transfer at the fastest speed code, so completion lands exactly 16 edges after the go write is accepted. It then times the clear write so that it is sampled on that same edge. The result is judged in three steps:
- Chip select must still be low just before that edge and high just after it, which confirms the edges coincide.
- The event bit must read back as set.
- A later clear must then remove the bit.

// File: rtl/spibuf_pkg.sv
package spibuf_pkg;
  localparam int DEF_BUF_DEPTH = 320;
  localparam int DEF_NUM_CS    = 7;
  localparam int DEF_ADDR_W    = 11;
  localparam int DEF_DATA_W    = 32;
  localparam int CNT_W   = 9;
  localparam int DEV_W   = 3;
  localparam int SPD_W   = 3;
  localparam int PH_W    = 5;
  // control word field positions
  localparam int GO_BIT    = 0;
  localparam int MODE_BIT  = 2;
  localparam int FORCE_BIT = 4;
  localparam int SPD_LSB   = 5;
  localparam int CNT_LSB   = 8;
  localparam int DEV_LSB   = 25;
  localparam int EVT_BIT   = 8;
  // address map
  localparam int RSP_BASE = 'h200;
  localparam int CTRL_OFF = 'h400;
  localparam int EVT_OFF  = 'h420;
  localparam int MASK_OFF = 'h424;

  typedef struct packed {
    logic loadFirst;  // load byte 0 into the transmit shifter
    logic sampleBit;  // capture MISO (rising serial edge)
    logic shiftBit;   // advance transmit shifter within a byte
    logic storeByte;  // write received byte to response buffer
    logic loadNext;   // load following command byte
  } dpStrobe_t;

  // full serial clock period in system clock cycles
  function automatic logic [PH_W-1:0] spdDiv(input logic [SPD_W-1:0] code);
    case (code)
      3'd0: spdDiv = PH_W'(2);
      3'd1: spdDiv = PH_W'(3);
      3'd2: spdDiv = PH_W'(4);
      3'd3: spdDiv = PH_W'(5);
      3'd4: spdDiv = PH_W'(6);
      default: spdDiv = PH_W'(30);
    endcase
  endfunction
endpackage

// File: rtl/spibuf_dp.sv
module spibuf_dp
  import spibuf_pkg::*;
#(
  parameter int BUF_DEPTH = DEF_BUF_DEPTH,
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int DATA_W    = DEF_DATA_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWrData,
  input  dpStrobe_t                  strobe,
  input  logic [$clog2(BUF_DEPTH)-1:0] byteIdx,
  input  logic                       miso,
  output logic                       mosi,
  output logic [DATA_W-1:0]          bufRdData
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam logic [ADDR_W-1:0] CMD_END  = ADDR_W'(BUF_DEPTH);
  localparam logic [ADDR_W-1:0] RSP_LO   = ADDR_W'(RSP_BASE);
  localparam logic [ADDR_W-1:0] RSP_HI   = ADDR_W'(RSP_BASE + BUF_DEPTH);

  logic [7:0] cmdBuf [BUF_DEPTH];
  logic [7:0] rspBuf [BUF_DEPTH];
  logic [7:0] txShift, rxShift;

  logic inCmd, inRsp;
  logic [IDX_W-1:0] cmdIdx, rspIdx, nextIdx;
  assign inCmd   = busAddr < CMD_END;
  assign inRsp   = (busAddr >= RSP_LO) && (busAddr < RSP_HI);
  assign cmdIdx  = IDX_W'(busAddr);
  assign rspIdx  = IDX_W'(busAddr - RSP_LO);
  assign nextIdx = byteIdx + IDX_W'(1);

  // buffer storage, no reset
  always_ff @(posedge clk) begin
    if (busWrEn && inCmd) cmdBuf[cmdIdx] <= busWrData[7:0];
    if (strobe.storeByte) rspBuf[byteIdx] <= rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      bufRdData <= '0;
    end else begin
      if (strobe.loadFirst)      txShift <= cmdBuf[0];
      else if (strobe.loadNext)  txShift <= cmdBuf[nextIdx];
      else if (strobe.shiftBit)  txShift <= {txShift[6:0], 1'b0};
      if (strobe.sampleBit)      rxShift <= {rxShift[6:0], miso};
      if (busRdEn && inCmd)      bufRdData <= DATA_W'(cmdBuf[cmdIdx]);
      else if (busRdEn && inRsp) bufRdData <= DATA_W'(rspBuf[rspIdx]);
      else                       bufRdData <= '0;
    end
  end

  assign mosi = txShift[7];

  // transmit shifter gets at most one update source per cycle (R2)
  assert_tx_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadFirst, strobe.shiftBit, strobe.loadNext}));
  // received bytes only land inside the buffer (R11)
  assert_store_in_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |-> (int'(byteIdx) < BUF_DEPTH));
endmodule

// File: rtl/spibuf_ctrl.sv
module spibuf_ctrl
  import spibuf_pkg::*;
#(
  parameter int BUF_DEPTH = DEF_BUF_DEPTH,
  parameter int NUM_CS    = DEF_NUM_CS,
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int DATA_W    = DEF_DATA_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWrData,
  output logic [DATA_W-1:0]          regRdData,
  output dpStrobe_t                  strobe,
  output logic [$clog2(BUF_DEPTH)-1:0] byteIdx,
  output logic                       sclk,
  output logic [NUM_CS-1:0]          csN,
  output logic                       irq
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(BUF_DEPTH);

  logic [DEV_W-1:0]  devSel;
  logic [CNT_W-1:0]  byteCnt;
  logic [SPD_W-1:0]  speed;
  logic              forceCe, modeSel;
  logic [DATA_W-1:0] maskReg;
  logic              eventBit, busy, phaseB;
  logic [PH_W-1:0]   phCnt;
  logic [2:0]        bitIdx;

  // bus decode
  logic ctrlWr, evWr, maskWr;
  assign ctrlWr = busWrEn && (busAddr == ADDR_W'(CTRL_OFF));
  assign evWr   = busWrEn && (busAddr == ADDR_W'(EVT_OFF));
  assign maskWr = busWrEn && (busAddr == ADDR_W'(MASK_OFF));

  logic [CNT_W-1:0] wrCnt, wrEff, effCount;
  assign wrCnt    = busWrData[CNT_LSB +: CNT_W];
  assign wrEff    = (wrCnt > MAX_CNT) ? MAX_CNT : wrCnt;
  assign effCount = (byteCnt > MAX_CNT) ? MAX_CNT : byteCnt;

  logic goReq, startXfer, zeroDone;
  assign goReq     = ctrlWr && !busy && busWrData[GO_BIT];
  assign startXfer = goReq && (wrEff != '0);
  assign zeroDone  = goReq && (wrEff == '0);

  // phase timing
  logic [PH_W-1:0] divFull, lowLen, highLen, phaseLen;
  assign divFull  = spdDiv(speed);
  assign lowLen   = divFull >> 1;
  assign highLen  = divFull - lowLen;
  assign phaseLen = phaseB ? highLen : lowLen;

  logic phEnd, bitEnd, byteEnd, lastByte, xferDone;
  assign phEnd    = busy && (phCnt == phaseLen - PH_W'(1));
  assign bitEnd   = phEnd && phaseB;
  assign byteEnd  = bitEnd && (bitIdx == 3'd0);
  assign lastByte = CNT_W'(byteIdx) == (effCount - CNT_W'(1));
  assign xferDone = byteEnd && lastByte;

  assign strobe.loadFirst = startXfer;
  assign strobe.sampleBit = phEnd && !phaseB;
  assign strobe.shiftBit  = bitEnd && (bitIdx != 3'd0);
  assign strobe.storeByte = byteEnd;
  assign strobe.loadNext  = byteEnd && !lastByte;

  logic evNext;
  assign evNext = (eventBit && !(evWr && busWrData[EVT_BIT])) || xferDone || zeroDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devSel <= '0; byteCnt <= '0; speed <= '0; forceCe <= 1'b0; modeSel <= 1'b0;
      maskReg <= '0; eventBit <= 1'b0; busy <= 1'b0; phaseB <= 1'b0;
      phCnt <= '0; bitIdx <= '0; byteIdx <= '0;
    end else begin
      if (ctrlWr && !busy) begin
        devSel  <= busWrData[DEV_LSB +: DEV_W];
        byteCnt <= wrCnt;
        speed   <= busWrData[SPD_LSB +: SPD_W];
        forceCe <= busWrData[FORCE_BIT];
        modeSel <= busWrData[MODE_BIT];
      end
      if (maskWr) maskReg <= busWrData;
      eventBit <= evNext;
      if (startXfer) begin
        busy <= 1'b1; phaseB <= 1'b0; phCnt <= '0; bitIdx <= 3'd7; byteIdx <= '0;
      end else if (busy) begin
        if (phEnd) begin
          phCnt  <= '0;
          phaseB <= !phaseB;
          if (phaseB) begin
            if (bitIdx == 3'd0) begin
              bitIdx <= 3'd7;
              if (lastByte) busy <= 1'b0;
              else          byteIdx <= byteIdx + IDX_W'(1);
            end else begin
              bitIdx <= bitIdx - 3'd1;
            end
          end
        end else begin
          phCnt <= phCnt + PH_W'(1);
        end
      end
    end
  end

  // register read port, one cycle latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else begin
      regRdData <= '0;
      if (busRdEn) begin
        if (busAddr == ADDR_W'(CTRL_OFF)) begin
          regRdData[DEV_LSB +: DEV_W] <= devSel;
          regRdData[CNT_LSB +: CNT_W] <= byteCnt;
          regRdData[SPD_LSB +: SPD_W] <= speed;
          regRdData[FORCE_BIT]        <= forceCe;
          regRdData[MODE_BIT]         <= modeSel;
          regRdData[GO_BIT]           <= busy;
        end else if (busAddr == ADDR_W'(EVT_OFF)) begin
          regRdData[EVT_BIT] <= eventBit;
        end else if (busAddr == ADDR_W'(MASK_OFF)) begin
          regRdData <= maskReg;
        end
      end
    end
  end

  // pin drive
  logic selOn;
  assign selOn = busy || forceCe;
  assign sclk  = busy ? phaseB : modeSel;
  assign irq   = eventBit && maskReg[EVT_BIT];
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = !(selOn && (devSel == DEV_W'(i)));
  end

  // at most one chip select low at any time (R5)
  assert_one_cs_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  // control fields frozen for the whole transfer (R9)
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable({devSel, byteCnt, speed, forceCe, modeSel}));
  // end of a transfer always leaves the event set (R6)
  assert_done_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> eventBit);
  // no serial clock movement while idle with a steady mode bit (R3)
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && $stable(modeSel)) |-> $stable(sclk));
  // a running transfer never has an empty effective count (R10)
  assert_no_empty_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (effCount != '0));
endmodule

// File: rtl/spibuf_host.sv
module spibuf_host
  import spibuf_pkg::*;
#(
  parameter int BUF_DEPTH = DEF_BUF_DEPTH,
  parameter int NUM_CS    = DEF_NUM_CS,
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int DATA_W    = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [NUM_CS-1:0] spiCsN,
  output logic              irq
);
  localparam int IDX_W = $clog2(BUF_DEPTH);

  dpStrobe_t         strobe;
  logic [IDX_W-1:0]  byteIdx;
  logic [DATA_W-1:0] regRdData, bufRdData;

  spibuf_ctrl #(.BUF_DEPTH(BUF_DEPTH), .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .regRdData(regRdData), .strobe(strobe), .byteIdx(byteIdx),
    .sclk(spiSclk), .csN(spiCsN), .irq(irq));

  spibuf_dp #(.BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .strobe(strobe), .byteIdx(byteIdx), .miso(spiMiso),
    .mosi(spiMosi), .bufRdData(bufRdData));

  assign busRdData = regRdData | bufRdData;
endmodule

// File: tb/test_spibuf_host.sv
module test_spibuf_host;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 320;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [10:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        spiSclk, spiMosi, spiMiso, irq;
  logic [6:0]  spiCsN;

  int checks = 0, fails = 0;
  int cycleCnt = 0;
  logic [7:0] cmdRef  [DEPTH];
  logic [7:0] slaveTx [DEPTH];
  logic [7:0] mosiCap [DEPTH];
  logic [12:0] bitCnt;
  int riseTotal = 0, toggleCnt = 0, lastRise = 0, prevRise = 0;
  logic csIdle;

  always #(CLK_PERIOD/2) clk = ~clk;

  spibuf_host i_spibuf_host (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiCsN(spiCsN), .irq(irq));

  // peripheral model: drives MISO from bit position, captures MOSI on rising clock
  assign csIdle  = &spiCsN;
  assign spiMiso = (!csIdle && bitCnt < 13'd2560) ? slaveTx[bitCnt[12:3]][3'd7 - bitCnt[2:0]] : 1'b0;
  always @(posedge spiSclk or posedge csIdle) begin
    if (csIdle) bitCnt <= '0;
    else begin
      if (bitCnt < 13'd2560) mosiCap[bitCnt[12:3]] <= {mosiCap[bitCnt[12:3]][6:0], spiMosi};
      bitCnt <= bitCnt + 13'd1;
    end
  end
  always @(posedge spiSclk) if (!csIdle) begin
    prevRise  <= lastRise;
    lastRise  <= cycleCnt;
    riseTotal <= riseTotal + 1;
  end
  always @(posedge spiSclk or negedge spiSclk) toggleCnt <= toggleCnt + 1;
  always @(negedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  function automatic logic [31:0] ctrlWord(input int dev, input int cnt, input int spd,
                                           input bit force_, input bit mode, input bit go);
    return (32'(dev) << 25) | (32'(cnt) << 8) | (32'(spd) << 5) |
           (32'(force_) << 4) | (32'(mode) << 2) | 32'(go);
  endfunction

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      busRead(11'h400, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic fillBuffers(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      cmdRef[i]  = 8'(i * 13 + seed);
      slaveTx[i] = 8'(i * 29 + 7 + seed * 3);
      busWrite(11'(i), 32'(cmdRef[i]));
    end
  endtask

  task automatic checkData(input int n, input string tag);
    logic [31:0] v;
    int bad = 0, badRsp = 0;
    for (int i = 0; i < n; i++) begin
      if (mosiCap[i] !== cmdRef[i]) bad++;
      busRead(11'(32'h200 + i), v);
      if (v[7:0] !== slaveTx[i]) badRsp++;
    end
    check(bad == 0, {tag, " mosi bytes"}, 32'(bad), 0);
    check(badRsp == 0, {tag, " response bytes"}, 32'(badRsp), 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(spiCsN === 7'h7f, "R1 cs idle", 32'(spiCsN), 32'h7f);
    check(spiSclk === 1'b0, "R1 sclk low", 32'(spiSclk), 0);
    check(irq === 1'b0, "R1 irq low", 32'(irq), 0);
    busRead(11'h400, v); check(v === 32'h0, "R1 control zero", v, 0);
    busRead(11'h420, v); check(v === 32'h0, "R1 event zero", v, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    fillBuffers(4, 1);
    busWrite(11'h400, ctrlWord(2, 4, 0, 0, 0, 1));
    repeat (3) @(negedge clk);
    check(spiCsN === 7'b1111011, "R5 cs during transfer", 32'(spiCsN), 32'h7b);
    busRead(11'h400, v); check(v[0] === 1'b1, "R6 go reads 1 while busy", v, 1);
    waitIdle();
    busRead(11'h400, v); check(v[0] === 1'b0, "R6 go self-clears", v, 0);
    check(spiCsN === 7'h7f, "R6 cs released", 32'(spiCsN), 32'h7f);
    busRead(11'h420, v); check(v === 32'h100, "R6 event set", v, 32'h100);
    checkData(4, "R2 mode0");
    busWrite(11'h420, 32'h100);
    busRead(11'h420, v); check(v === 32'h0, "R7 event cleared", v, 0);
  endtask

  task automatic t_mode3();
    logic [31:0] v;
    busWrite(11'h400, ctrlWord(5, 3, 1, 0, 1, 0));
    @(negedge clk);
    check(spiSclk === 1'b1, "R3 mode3 idles high", 32'(spiSclk), 1);
    fillBuffers(3, 9);
    busWrite(11'h400, ctrlWord(5, 3, 1, 0, 1, 1));
    repeat (2) @(negedge clk);
    check(spiCsN === 7'b1011111, "R5 cs index5", 32'(spiCsN), 32'h5f);
    waitIdle();
    check(spiSclk === 1'b1, "R3 mode3 high after transfer", 32'(spiSclk), 1);
    checkData(3, "R3 mode3 data");
    busWrite(11'h400, ctrlWord(5, 3, 1, 0, 0, 0));
    @(negedge clk);
    check(spiSclk === 1'b0, "R3 mode0 idles low", 32'(spiSclk), 0);
    busWrite(11'h420, 32'h100);
  endtask

  task automatic t_speed();
    int expDiv;
    fillBuffers(1, 4);
    for (int c = 0; c < 8; c++) begin
      expDiv = (c < 5) ? c + 2 : 30;
      busWrite(11'h400, ctrlWord(0, 1, c, 0, 0, 1));
      waitIdle();
      check(lastRise - prevRise == expDiv, $sformatf("R4 period code %0d", c),
            32'(lastRise - prevRise), 32'(expDiv));
    end
    busWrite(11'h420, 32'h100);
  endtask

  task automatic t_force();
    busWrite(11'h400, ctrlWord(3, 0, 0, 1, 0, 0));
    @(negedge clk);
    check(spiCsN === 7'b1110111, "R5 force holds index3", 32'(spiCsN), 32'h77);
    busWrite(11'h400, ctrlWord(7, 0, 0, 1, 0, 0));
    @(negedge clk);
    check(spiCsN === 7'h7f, "R5 index7 selects none", 32'(spiCsN), 32'h7f);
    busWrite(11'h400, ctrlWord(7, 1, 0, 0, 0, 1));
    repeat (3) @(negedge clk);
    check(spiCsN === 7'h7f, "R5 index7 none during transfer", 32'(spiCsN), 32'h7f);
    waitIdle();
    busWrite(11'h400, ctrlWord(3, 0, 0, 1, 0, 0));
    busWrite(11'h400, ctrlWord(3, 0, 0, 0, 0, 0));
    @(negedge clk);
    check(spiCsN === 7'h7f, "R5 force clear releases", 32'(spiCsN), 32'h7f);
    busWrite(11'h420, 32'h100);
  endtask

  task automatic t_irq();
    busWrite(11'h424, 32'h0);
    busWrite(11'h400, ctrlWord(0, 0, 0, 0, 0, 1));
    @(negedge clk);
    check(irq === 1'b0, "R8 masked event no irq", 32'(irq), 0);
    busWrite(11'h424, 32'h100);
    @(negedge clk);
    check(irq === 1'b1, "R8 unmasked event irq", 32'(irq), 1);
    busWrite(11'h420, 32'h100);
    @(negedge clk);
    check(irq === 1'b0, "R8 irq drops on clear", 32'(irq), 0);
    busWrite(11'h424, 32'h0);
  endtask

  task automatic t_setwins();
    logic [31:0] v;
    fillBuffers(1, 2);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 11'h400; busWrData = ctrlWord(1, 1, 0, 0, 0, 1);
    @(negedge clk);
    busWrEn = 1'b0;
    repeat (15) @(negedge clk);
    check(spiCsN === 7'b1111101, "R7 still busy before last edge", 32'(spiCsN), 32'h7d);
    busWrEn = 1'b1; busAddr = 11'h420; busWrData = 32'h100;
    @(negedge clk);
    busWrEn = 1'b0;
    check(spiCsN === 7'h7f, "R7 completion on clear edge", 32'(spiCsN), 32'h7f);
    busRead(11'h420, v); check(v === 32'h100, "R7 set wins over clear", v, 32'h100);
    busWrite(11'h420, 32'h100);
    busRead(11'h420, v); check(v === 32'h0, "R7 later clear", v, 0);
  endtask

  task automatic t_busy();
    logic [31:0] v, orig;
    fillBuffers(2, 5);
    orig = ctrlWord(1, 2, 7, 0, 0, 0);
    busWrite(11'h400, orig | 32'h1);
    repeat (10) @(negedge clk);
    busWrite(11'h400, ctrlWord(6, 9, 0, 1, 1, 1));
    @(negedge clk);
    check(spiCsN === 7'b1111101, "R9 cs unchanged by busy write", 32'(spiCsN), 32'h7d);
    waitIdle();
    busRead(11'h400, v); check(v === orig, "R9 control unchanged", v, orig);
    checkData(2, "R9 transfer intact");
    busWrite(11'h420, 32'h100);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int t0;
    t0 = toggleCnt;
    busWrite(11'h400, ctrlWord(1, 0, 0, 0, 0, 1));
    check(spiCsN === 7'h7f, "R10 no chip select", 32'(spiCsN), 32'h7f);
    busRead(11'h420, v); check(v === 32'h100, "R10 immediate event", v, 32'h100);
    check(toggleCnt == t0, "R10 no clock edge", 32'(toggleCnt), 32'(t0));
    busRead(11'h400, v); check(v[0] === 1'b0, "R10 go clear", v, 0);
    busWrite(11'h420, 32'h100);
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    int r0;
    fillBuffers(DEPTH, 11);
    r0 = riseTotal;
    busWrite(11'h400, ctrlWord(4, 400, 0, 0, 0, 1));
    waitIdle();
    check(riseTotal - r0 == DEPTH * 8, "R11 clamped to 320 bytes", 32'(riseTotal - r0), 32'(DEPTH * 8));
    busRead(11'h400, v); check(v[16:8] === 9'd400, "R11 count reads as written", 32'(v[16:8]), 400);
    checkData(DEPTH, "R11 full buffer");
    busRead(11'h420, v); check(v === 32'h100, "R11 event set", v, 32'h100);
    busWrite(11'h420, 32'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mode3();
    t_speed();
    t_force();
    t_irq();
    t_setwins();
    t_busy();
    t_zero();
    t_clamp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule